// File: doc/BRIEF.md
# SMBus Register-Pointer Slave Interface

This block is a two-wire serial bus slave for a register file. It samples the SCL and SDA lines with the system clock and finds START and STOP conditions. It compares the first byte of each transaction with a 7-bit address, and it drives only an open-drain enable for SDA. The upper five address bits are fixed at `01011`. The lower two come from strap inputs. On the register side it has one port: a pointer-driven address, write data, a one-cycle write strobe, and combinational read data from the array.

The first byte after the address in a write transaction always loads a persistent pointer. A second byte, if one follows, is written to the register the pointer selects. A read transaction has no pointer phase. It returns the register that the retained pointer addresses, so a read can run alone once the pointer has been set. The pointer never advances by itself.

Top module: `smb_ptr_slave`

## Requirements
- R1: The slave acknowledges an address byte whose seven MSB-first bits equal `0101 1` followed by `addr_strap[1]` and `addr_strap[0]`. It acknowledges by asserting `sda_oe` (SDA pulled low) through the ninth SCL pulse. The eighth bit is R/W, where 0 means master write and 1 means master read.
- R2: If the address does not match, `sda_oe` stays low and every later byte is ignored until the next START or STOP. No pointer change and no write strobe occur.
- R3: In a write transaction, the first byte after the address is stored in the pointer, and `reg_addr` shows the pointer value.
- R4: A write transaction that carries only the pointer byte updates the pointer and produces no `reg_we` pulse.
- R5: A second byte in a write transaction produces exactly one single-cycle `reg_we` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R6: Bytes after the second in a write transaction are acknowledged and discarded. The pointer does not increment.
- R7: A read transaction shifts out `reg_rdata` at the current pointer, MSB first, with no pointer byte. If the master acknowledges, the same register is sent again.
- R8: After a master no-acknowledge on a read byte, the slave keeps SDA released until the next START.
- R9: A repeated START at any point resets the bit count and returns to address reception. The pointer value is kept.
- R10: After reset the pointer is 0x00, `sda_oe` is low and `reg_we` is low.
- R11: A STOP (SDA rising while SCL is high) ends the transaction from any state. An unfinished data byte is dropped without a write.
- R12: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_strap | input | 2 | Strap bits forming the two low address bits |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 8 | Register index, equal to the pointer |
| reg_wdata | output | 8 | Data for the register write |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Read data of the register at `reg_addr` |

## Verification
A bus edge reaches the transfer state on the third rising clock edge after the pin changes: two synchronizer flops, then the state register that acts on the detected edge. `sda_oe`, `reg_we` and the pointer therefore settle three cycles after the SCL fall, rising edge or START/STOP that causes them. The behavioural master holds every SCL half-phase for at least eight clocks and drives and samples on falling clock edges. It reads SDA in the middle of each SCL high phase and checks register contents and `reg_addr` only after the STOP phase has elapsed, so every result has settled well before it is sampled.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_PARK
    } smb_state_e;

    typedef struct packed {
        smb_state_e          st;
        logic [CNT_W-1:0]    bit_cnt;
        logic [BYTE_W-1:0]   shreg;
        logic [1:0]          byte_idx;
        logic                rw;
        logic [BYTE_W-1:0]   ptr;
        logic                oe;
        logic                we;
        logic [BYTE_W-1:0]   wdata;
        logic                more;
    } smb_regs_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s,
    output logic line_q
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= 1'b1;
                end else begin
                    chain_q <= line_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '1;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], line_i};
                end
            end
        end
    endgenerate

    assign line_s = chain_q[STAGES-1];

    // One extra stage holds the previous synchronized value for edge finding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= 1'b1;
        end else begin
            line_q <= line_s;
        end
    end

endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect (
    input  logic scl_s,
    input  logic scl_q,
    input  logic sda_s,
    input  logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);

    logic scl_high;

    always_comb begin
        scl_high = scl_s & scl_q;
        scl_rise = scl_s & ~scl_q;
        scl_fall = ~scl_s & scl_q;
        start_c  = scl_high & sda_q & ~sda_s;
        stop_c   = scl_high & ~sda_q & sda_s;
    end

endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
    import smb_pkg::*;
#(
    parameter logic [4:0] ADDR_PREFIX = 5'b01011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_c,
    input  logic              stop_c,
    input  logic              sda_s,
    input  logic [1:0]        strap,
    input  logic [BYTE_W-1:0] rdata,
    output logic              oe,
    output logic [BYTE_W-1:0] ptr,
    output logic [BYTE_W-1:0] wdata,
    output logic              we,
    output smb_state_e        state
);

    localparam logic [CNT_W-1:0] CNT_FULL    = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_TX_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [1:0]       IDX_ADDR    = 2'd0;
    localparam logic [1:0]       IDX_PTR     = 2'd1;
    localparam logic [1:0]       IDX_DATA    = 2'd2;
    localparam logic [1:0]       IDX_EXTRA   = 2'd3;

    smb_regs_t q_q;
    smb_regs_t q_d;
    logic      addr_hit;

    assign addr_hit = (q_q.shreg[BYTE_W-1:1] == {ADDR_PREFIX, strap});

    always_comb begin
        q_d    = q_q;
        q_d.we = 1'b0;
        if (stop_c) begin
            q_d.st   = ST_IDLE;
            q_d.oe   = 1'b0;
            q_d.more = 1'b0;
        end else if (start_c) begin
            q_d.st       = ST_RX;
            q_d.bit_cnt  = '0;
            q_d.byte_idx = IDX_ADDR;
            q_d.oe       = 1'b0;
            q_d.more     = 1'b0;
        end else begin
            unique case (q_q.st)
                ST_RX: begin
                    if (scl_rise && (q_q.bit_cnt < CNT_FULL)) begin
                        q_d.shreg   = {q_q.shreg[BYTE_W-2:0], sda_s};
                        q_d.bit_cnt = q_q.bit_cnt + 1'b1;
                    end else if (scl_fall && (q_q.bit_cnt == CNT_FULL)) begin
                        q_d.bit_cnt = '0;
                        if (q_q.byte_idx == IDX_ADDR) begin
                            if (addr_hit) begin
                                q_d.rw = q_q.shreg[0];
                                q_d.st = ST_ACK;
                                q_d.oe = 1'b1;
                            end else begin
                                q_d.st = ST_PARK;
                            end
                        end else begin
                            q_d.st = ST_ACK;
                            q_d.oe = 1'b1;
                            if (q_q.byte_idx == IDX_PTR) begin
                                q_d.ptr = q_q.shreg;
                            end else if (q_q.byte_idx == IDX_DATA) begin
                                q_d.we    = 1'b1;
                                q_d.wdata = q_q.shreg;
                            end
                        end
                        if (q_q.byte_idx != IDX_EXTRA) begin
                            q_d.byte_idx = q_q.byte_idx + 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        q_d.bit_cnt = '0;
                        if (q_q.rw) begin
                            q_d.st    = ST_TX;
                            q_d.shreg = rdata;
                            q_d.oe    = ~rdata[BYTE_W-1];
                        end else begin
                            q_d.st = ST_RX;
                            q_d.oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q_q.bit_cnt == CNT_TX_LAST) begin
                            q_d.st      = ST_MACK;
                            q_d.oe      = 1'b0;
                            q_d.bit_cnt = '0;
                        end else begin
                            q_d.shreg   = {q_q.shreg[BYTE_W-2:0], 1'b0};
                            q_d.bit_cnt = q_q.bit_cnt + 1'b1;
                            q_d.oe      = ~q_q.shreg[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        q_d.more = ~sda_s;
                    end else if (scl_fall) begin
                        q_d.more = 1'b0;
                        if (q_q.more) begin
                            q_d.st      = ST_TX;
                            q_d.shreg   = rdata;
                            q_d.oe      = ~rdata[BYTE_W-1];
                            q_d.bit_cnt = '0;
                        end else begin
                            q_d.st = ST_PARK;
                        end
                    end
                end
                default: begin
                    q_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{st: ST_IDLE, bit_cnt: '0, shreg: '0, byte_idx: '0,
                     rw: 1'b0, ptr: '0, oe: 1'b0, we: 1'b0, wdata: '0,
                     more: 1'b0};
        end else begin
            q_q <= q_d;
        end
    end

    assign oe    = q_q.oe;
    assign ptr   = q_q.ptr;
    assign wdata = q_q.wdata;
    assign we    = q_q.we;
    assign state = q_q.st;

endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave
    import smb_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [4:0]  ADDR_PREFIX = 5'b01011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        addr_strap,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata
);

    localparam int unsigned N_LINES = 2;
    localparam int unsigned L_SCL   = 0;
    localparam int unsigned L_SDA   = 1;

    logic [N_LINES-1:0] lines_raw;
    logic [N_LINES-1:0] lines_s;
    logic [N_LINES-1:0] lines_q;
    logic               scl_s;
    logic               scl_q;
    logic               sda_s;
    logic               sda_q;
    logic               scl_rise;
    logic               scl_fall;
    logic               start_c;
    logic               stop_c;
    smb_state_e         fsm_state;

    assign lines_raw[L_SCL] = scl_i;
    assign lines_raw[L_SDA] = sda_i;

    generate
        for (genvar gi = 0; gi < N_LINES; gi++) begin : g_sync
            smb_line_sync #(
                .STAGES (SYNC_STAGES)
            ) u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .line_i (lines_raw[gi]),
                .line_s (lines_s[gi]),
                .line_q (lines_q[gi])
            );
        end
    endgenerate

    assign scl_s = lines_s[L_SCL];
    assign scl_q = lines_q[L_SCL];
    assign sda_s = lines_s[L_SDA];
    assign sda_q = lines_q[L_SDA];

    smb_cond_detect u_cond (
        .scl_s    (scl_s),
        .scl_q    (scl_q),
        .sda_s    (sda_s),
        .sda_q    (sda_q),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    smb_xfer_fsm #(
        .ADDR_PREFIX (ADDR_PREFIX)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c),
        .sda_s    (sda_s),
        .strap    (addr_strap),
        .rdata    (reg_rdata),
        .oe       (sda_oe),
        .ptr      (reg_addr),
        .wdata    (reg_wdata),
        .we       (reg_we),
        .state    (fsm_state)
    );

endmodule

// File: rtl/smb_ptr_slave_chk.sv
module smb_ptr_slave_chk
    import smb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              sda_oe,
    input logic              reg_we,
    input logic [BYTE_W-1:0] reg_addr,
    input smb_state_e        st
);

    AST_OE_ON_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s)); // R12

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R5

    AST_WE_PTR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_addr == $past(reg_addr))); // R6

    AST_PTR_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != $past(reg_addr)) |-> (st == ST_ACK)); // R3

    AST_PARK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PARK) |-> (!sda_oe && !reg_we)); // R2

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe); // R8

endmodule

bind smb_ptr_slave smb_ptr_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .st       (fsm_state)
);

// File: tb/smb_ptr_slave_bench.sv
module smb_ptr_slave_bench;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] strap = 2'b01;
    logic       sda_oe;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;
    logic [7:0] mem [256];
    wire        sda_line = m_sda & ~sda_oe;
    int         we_cnt = 0;
    int         oe_viol = 0;
    int         n_chk = 0;
    int         n_bad = 0;
    logic       prev_oe = 1'b0;

    always #2 clk = ~clk;

    smb_ptr_slave u_smb_ptr_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .addr_strap (strap),
        .sda_oe     (sda_oe),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_we     (reg_we),
        .reg_rdata  (reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    end

    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (sda_oe != prev_oe && m_scl) oe_viol++;
        prev_oe = sda_oe;
    end

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bstart();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bstop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq(); wq();
    endtask

    task automatic wbit(input logic b);
        m_sda = b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic rbit(output logic b);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        b = sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic mbit(input logic b, output logic oe_seen);
        m_sda = b; wq();
        m_scl = 1'b1; wq();
        oe_seen = sda_oe; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic wbyte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(a);
        ack = ~a;
    endtask

    task automatic rbyte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) rbit(v[i]);
    endtask

    function automatic logic [7:0] adr(input logic [1:0] s, input logic rw);
        return {5'b01011, s, rw};
    endfunction

    task automatic t_reset();
        chk("R10", "sda_oe after reset", int'(sda_oe), 0);
        chk("R10", "reg_we after reset", int'(reg_we), 0);
        chk("R10", "pointer after reset", int'(reg_addr), 0);
    endtask

    task automatic t_send_byte();
        logic a;
        int w0 = we_cnt;
        bstart();
        wbyte(adr(2'b01, 1'b0), a); chk("R1", "address ack", int'(a), 1);
        wbyte(8'h25, a);            chk("R3", "pointer ack", int'(a), 1);
        bstop();
        chk("R3", "pointer value", int'(reg_addr), 'h25);
        chk("R4", "no write on pointer-only", we_cnt - w0, 0);
    endtask

    task automatic t_write_reg();
        logic a;
        int w0 = we_cnt;
        bstart();
        wbyte(adr(2'b01, 1'b0), a);
        wbyte(8'h10, a);
        wbyte(8'hA5, a); chk("R5", "data ack", int'(a), 1);
        bstop();
        chk("R5", "written value", int'(mem[8'h10]), 'hA5);
        chk("R5", "write count", we_cnt - w0, 1);
        chk("R5", "pointer after write", int'(reg_addr), 'h10);
    endtask

    task automatic t_read_alone();
        logic a, oe_seen;
        logic [7:0] v;
        bstart();
        wbyte(adr(2'b01, 1'b1), a); chk("R7", "read address ack", int'(a), 1);
        rbyte(v);                   chk("R7", "read data", int'(v), 'hA5);
        mbit(1'b1, oe_seen);        chk("R8", "released on nack", int'(oe_seen), 0);
        wq();                       chk("R8", "released after nack", int'(sda_oe), 0);
        bstop();
        bstart();
        wbyte(adr(2'b01, 1'b0), a);
        wbyte(8'h77, a);
        bstop();
        bstart();
        wbyte(adr(2'b01, 1'b1), a);
        rbyte(v);                   chk("R7", "read preset reg", int'(v), 'h77 ^ 'h5A);
        mbit(1'b1, oe_seen);
        bstop();
    endtask

    task automatic t_read_repeat();
        logic a, oe_seen;
        logic [7:0] v;
        bstart();
        wbyte(adr(2'b01, 1'b1), a);
        rbyte(v);            chk("R7", "first of two", int'(v), 'h77 ^ 'h5A);
        mbit(1'b0, oe_seen);
        rbyte(v);            chk("R7", "same reg again", int'(v), 'h77 ^ 'h5A);
        mbit(1'b1, oe_seen);
        bstop();
        chk("R7", "pointer not advanced", int'(reg_addr), 'h77);
    endtask

    task automatic t_mismatch();
        logic a;
        int w0 = we_cnt;
        bstart();
        wbyte(adr(2'b10, 1'b0), a); chk("R2", "no ack on mismatch", int'(a), 0);
        wbyte(8'h55, a);            chk("R2", "later byte ignored", int'(a), 0);
        wbyte(8'h66, a);
        bstop();
        chk("R2", "pointer kept", int'(reg_addr), 'h77);
        chk("R2", "no write", we_cnt - w0, 0);
        strap = 2'b10;
        wq();
        bstart();
        wbyte(adr(2'b10, 1'b0), a); chk("R1", "ack with new strap", int'(a), 1);
        bstop();
        strap = 2'b01;
        wq();
    endtask

    task automatic t_extra_bytes();
        logic a;
        logic a2, a3;
        int w0 = we_cnt;
        bstart();
        wbyte(adr(2'b01, 1'b0), a);
        wbyte(8'h30, a);
        wbyte(8'h11, a);
        wbyte(8'h22, a2);
        wbyte(8'h33, a3);
        bstop();
        chk("R6", "extra acks", int'({a2, a3}), 3);
        chk("R6", "first data kept", int'(mem[8'h30]), 'h11);
        chk("R6", "next reg untouched", int'(mem[8'h31]), 'h31 ^ 'h5A);
        chk("R6", "single write", we_cnt - w0, 1);
        chk("R6", "pointer not advanced", int'(reg_addr), 'h30);
    endtask

    task automatic t_rep_start();
        logic a, oe_seen;
        logic [7:0] v;
        bstart();
        wbyte(adr(2'b01, 1'b0), a);
        wbyte(8'h44, a);
        bstart();
        wbyte(adr(2'b01, 1'b1), a); chk("R9", "ack after repeated start", int'(a), 1);
        rbyte(v);                   chk("R9", "read via kept pointer", int'(v), 'h44 ^ 'h5A);
        mbit(1'b1, oe_seen);
        bstop();
        bstart();
        wbyte(adr(2'b01, 1'b0), a);
        wbit(1'b1); wbit(1'b0); wbit(1'b1);
        bstart();
        wbyte(adr(2'b01, 1'b0), a); chk("R9", "ack after mid-byte restart", int'(a), 1);
        wbyte(8'h50, a);
        wbyte(8'h99, a);
        bstop();
        chk("R9", "write after restart", int'(mem[8'h50]), 'h99);
    endtask

    task automatic t_stop_abort();
        logic a;
        int w0 = we_cnt;
        bstart();
        wbyte(adr(2'b01, 1'b0), a);
        wbyte(8'h60, a);
        wbit(1'b1); wbit(1'b1); wbit(1'b0); wbit(1'b0);
        bstop();
        chk("R11", "no write on abort", we_cnt - w0, 0);
        chk("R11", "pointer kept", int'(reg_addr), 'h60);
        bstart();
        wbyte(adr(2'b01, 1'b0), a);
        wbyte(8'h61, a);
        wbyte(8'hC3, a);
        bstop();
        chk("R11", "fresh write after stop", int'(mem[8'h61]), 'hC3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_send_byte();
        t_write_reg();
        t_read_alone();
        t_read_repeat();
        t_mismatch();
        t_extra_bytes();
        t_rep_start();
        t_stop_abort();
        chk("R12", "oe changes with SCL high", oe_viol, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule